// File: doc/BRIEF.md
# Product Term Steering Allocator

This block sits at the output of one five-term cluster in a programmable logic array model. Five product-term values come in together with one steering bit per term. Each term either joins the cluster's OR sum or takes the control role that belongs to its position. The OR sum leaves on two ports. One port is a fast path to the I/O cell, and the other feeds the next allocation stage.

Each position has its own fixed control role. The lowest term becomes the single-term operand of the macrocell XOR/OR input. The next term becomes a private clock. The third term becomes either an initialization or a clock enable, and a separate select bit picks which. The fourth term becomes a second initialization. The highest term becomes the output enable. When a term stays on logic, its control output rests at a harmless default. The whole block is combinational, so every output follows its inputs in the same cycle.

Top module: `pts_allocator`

## Requirements
- R1: Term index k (0..4) of `pt_in` is steered to control when `steer_ctl[k]` is 1 and to logic when it is 0. This mapping holds for every one of the 32 steering masks.
- R2: `or_bypass` equals the OR of all terms whose steering bit is 0. A term steered to control adds 0 to the sum, so all-control steering gives 0.
- R3: `or_to_alloc` always equals `or_bypass`.
- R4: `xor_opnd` equals `pt_in[0]` when `steer_ctl[0]` is 1, and 0 otherwise.
- R5: `mc_clk` equals `pt_in[1]` when `steer_ctl[1]` is 1, and equals `glb_clk` otherwise.
- R6: With `steer_ctl[2]` at 1 and `ce_sel` at 1, `mc_ce` equals `pt_in[2]` and `mc_init_a` is 0. With `steer_ctl[2]` at 1 and `ce_sel` at 0, `mc_init_a` equals `pt_in[2]` and `mc_ce` is 1.
- R7: `mc_init_b` equals `pt_in[3]` when `steer_ctl[3]` is 1, and 0 otherwise.
- R8: `mc_oe` equals `pt_in[4]` when `steer_ctl[4]` is 1, and 0 otherwise.
- R9: With `steer_ctl[2]` at 0, `ce_sel` has no effect: `mc_ce` is 1 and `mc_init_a` is 0 for both values of `ce_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | 5 | Product-term values, index 0 is the lowest term |
| steer_ctl | input | 5 | Per-term steering, 1 = control role, 0 = OR sum |
| ce_sel | input | 1 | Role of term 2 under control: 1 = clock enable, 0 = initialization |
| glb_clk | input | 1 | Global clock used when term 1 is on logic |
| or_bypass | output | 1 | Cluster OR sum toward the I/O cell |
| or_to_alloc | output | 1 | Cluster OR sum toward the allocation stage |
| xor_opnd | output | 1 | Single-term XOR/OR operand |
| mc_clk | output | 1 | Selected macrocell clock |
| mc_ce | output | 1 | Clock enable, active high |
| mc_init_a | output | 1 | Initialization taken from term 2 |
| mc_init_b | output | 1 | Initialization taken from term 3 |
| mc_oe | output | 1 | Output enable, active high |

## Verification
The sweep targets four failure modes.

The first is a control-steered term that still reaches the OR sum. Such a design shows a 1 on the OR ports when only control-steered terms are high.

The second is an index slip between a term and its role. Such a design moves one term's value onto the wrong control pin for some masks.

The third is a term-2 role select that leaks through while term 2 is on logic. Such a design drops the clock enable or raises an initialization for one value of `ce_sel`.

The fourth is a wrong resting value. Such a design gates the clock or enables the output while the matching term sits on logic.

// File: rtl/pts_pkg.sv
package pts_pkg;
   localparam int unsigned PTS_TERMS = 5;

   typedef enum logic [2:0] {
      ROLE_XOR  = 3'd0,
      ROLE_CLK  = 3'd1,
      ROLE_CEIN = 3'd2,
      ROLE_INIT = 3'd3,
      ROLE_OE   = 3'd4
   } pts_role_e;

   typedef struct packed {
      logic xor_opnd;
      logic clk;
      logic ce;
      logic init_a;
      logic init_b;
      logic oe;
   } pts_ctl_t;

   localparam pts_ctl_t PTS_CTL_IDLE = '{xor_opnd: 1'b0, clk: 1'b0, ce: 1'b1,
                                        init_a: 1'b0, init_b: 1'b0, oe: 1'b0};
endpackage

// File: rtl/pts_term_split.sv
module pts_term_split (
   input  logic term_val,
   input  logic to_ctl,
   output logic logic_part,
   output logic ctl_part
);
   always_comb begin
      logic_part = term_val & ~to_ctl;
      ctl_part   = term_val &  to_ctl;
   end
endmodule

// File: rtl/pts_or_sum.sv
module pts_or_sum #(
   parameter int unsigned WIDTH = 5
) (
   input  logic [WIDTH-1:0] terms,
   output logic             sum
);
   localparam int unsigned LVLS = (WIDTH <= 1) ? 1 : $clog2(WIDTH);
   localparam int unsigned PADW = 1 << LVLS;

   logic [PADW-1:0] padded;
   always_comb begin
      padded = '0;
      padded[WIDTH-1:0] = terms;
   end

   // Balanced reduction tree, one stage per level.
   logic [PADW-1:0] stage [LVLS+1];
   assign stage[0] = padded;

   for (genvar l = 0; l < LVLS; l++) begin : g_lvl
      localparam int unsigned N = PADW >> (l + 1);
      for (genvar i = 0; i < PADW; i++) begin : g_node
         if (i < N) begin : g_or
            assign stage[l+1][i] = stage[l][2*i] | stage[l][2*i+1];
         end else begin : g_zero
            assign stage[l+1][i] = 1'b0;
         end
      end
   end

   assign sum = stage[LVLS][0];
endmodule

// File: rtl/pts_ctl_map.sv
module pts_ctl_map
   import pts_pkg::*;
#(
   parameter int unsigned TERMS = 5
) (
   input  logic [TERMS-1:0] ctl_val,
   input  logic [TERMS-1:0] ctl_en,
   input  logic             ce_sel,
   input  logic             glb_clk,
   output pts_ctl_t         ctl
);
   logic use_ce;
   logic use_init;

   always_comb begin
      use_ce   = ctl_en[ROLE_CEIN] &  ce_sel;
      use_init = ctl_en[ROLE_CEIN] & ~ce_sel;

      ctl = PTS_CTL_IDLE;
      ctl.clk = glb_clk;
      if (ctl_en[ROLE_XOR])  ctl.xor_opnd = ctl_val[ROLE_XOR];
      if (ctl_en[ROLE_CLK])  ctl.clk      = ctl_val[ROLE_CLK];
      if (use_ce)            ctl.ce       = ctl_val[ROLE_CEIN];
      if (use_init)          ctl.init_a   = ctl_val[ROLE_CEIN];
      if (ctl_en[ROLE_INIT]) ctl.init_b   = ctl_val[ROLE_INIT];
      if (ctl_en[ROLE_OE])   ctl.oe       = ctl_val[ROLE_OE];
   end
endmodule

// File: rtl/pts_allocator.sv
module pts_allocator
   import pts_pkg::*;
#(
   parameter int unsigned NUM_TERMS = 5
) (
   input  logic [NUM_TERMS-1:0] pt_in,
   input  logic [NUM_TERMS-1:0] steer_ctl,
   input  logic                 ce_sel,
   input  logic                 glb_clk,
   output logic                 or_bypass,
   output logic                 or_to_alloc,
   output logic                 xor_opnd,
   output logic                 mc_clk,
   output logic                 mc_ce,
   output logic                 mc_init_a,
   output logic                 mc_init_b,
   output logic                 mc_oe
);
   if (NUM_TERMS != PTS_TERMS) begin : g_bad_terms
      $error("pts_allocator: NUM_TERMS must equal five, one term per control role");
   end

   logic [NUM_TERMS-1:0] logic_terms;
   logic [NUM_TERMS-1:0] ctl_terms;
   logic                 sum;
   pts_ctl_t             ctl;

   for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
      pts_term_split u_split (
         .term_val  (pt_in[k]),
         .to_ctl    (steer_ctl[k]),
         .logic_part(logic_terms[k]),
         .ctl_part  (ctl_terms[k])
      );
   end

   pts_or_sum #(.WIDTH(NUM_TERMS)) u_or (
      .terms(logic_terms),
      .sum  (sum)
   );

   pts_ctl_map #(.TERMS(NUM_TERMS)) u_map (
      .ctl_val(ctl_terms),
      .ctl_en (steer_ctl),
      .ce_sel (ce_sel),
      .glb_clk(glb_clk),
      .ctl    (ctl)
   );

   assign or_bypass   = sum;
   assign or_to_alloc = sum;
   assign xor_opnd    = ctl.xor_opnd;
   assign mc_clk      = ctl.clk;
   assign mc_ce       = ctl.ce;
   assign mc_init_a   = ctl.init_a;
   assign mc_init_b   = ctl.init_b;
   assign mc_oe       = ctl.oe;
endmodule

// File: rtl/pts_allocator_chk.sv
module pts_allocator_chk #(
   parameter int unsigned NUM_TERMS = 5
) (
   input logic [NUM_TERMS-1:0] pt_in,
   input logic [NUM_TERMS-1:0] steer_ctl,
   input logic                 ce_sel,
   input logic                 glb_clk,
   input logic                 or_bypass,
   input logic                 or_to_alloc,
   input logic                 xor_opnd,
   input logic                 mc_clk,
   input logic                 mc_ce,
   input logic                 mc_init_a,
   input logic                 mc_init_b,
   input logic                 mc_oe
);
   always_comb begin
      AST_PATHS_AGREE: assert (or_bypass == or_to_alloc); // R3
      AST_CTL_NOT_SUMMED: assert (!((pt_in & ~steer_ctl) == '0) || !or_bypass); // R2
      AST_XOR_IDLE: assert (steer_ctl[0] || !xor_opnd); // R4
      AST_CLK_GLOBAL: assert (steer_ctl[1] || (mc_clk == glb_clk)); // R5
      AST_CE_INIT_EXCL: assert (!(ce_sel && mc_init_a)); // R6
      AST_CE_SEL_IGNORED: assert (steer_ctl[2] || (mc_ce && !mc_init_a)); // R9
      AST_INITB_IDLE: assert (steer_ctl[3] || !mc_init_b); // R7
      AST_OE_IDLE: assert (steer_ctl[4] || !mc_oe); // R8
   end
endmodule

bind pts_allocator pts_allocator_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (.*);

// File: tb/sim_pts_allocator.sv
module sim_pts_allocator;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] pt_in = '0;
   logic [4:0] steer_ctl = '0;
   logic       ce_sel = 1'b0;
   logic       glb_clk = 1'b0;
   logic or_bypass, or_to_alloc, xor_opnd, mc_clk, mc_ce, mc_init_a, mc_init_b, mc_oe;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pts_allocator u0 (
      .pt_in(pt_in), .steer_ctl(steer_ctl), .ce_sel(ce_sel), .glb_clk(glb_clk),
      .or_bypass(or_bypass), .or_to_alloc(or_to_alloc), .xor_opnd(xor_opnd),
      .mc_clk(mc_clk), .mc_ce(mc_ce), .mc_init_a(mc_init_a),
      .mc_init_b(mc_init_b), .mc_oe(mc_oe)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b pt=%b steer=%b sel=%b gclk=%b",
                  req, act, exp, pt_in, steer_ctl, ce_sel, glb_clk);
      end
   endtask

   // Expected values come from the requirement text, per output.
   task automatic check_all();
      logic e_or, e_ce, e_ia;
      e_or = 1'b0;
      for (int k = 0; k < 5; k++) if (!steer_ctl[k] && pt_in[k]) e_or = 1'b1; // R1 R2
      chk("R2", or_bypass, e_or);
      chk("R3", or_to_alloc, e_or);
      chk("R4", xor_opnd, steer_ctl[0] ? pt_in[0] : 1'b0);
      chk("R5", mc_clk, steer_ctl[1] ? pt_in[1] : glb_clk);
      e_ce = 1'b1;
      e_ia = 1'b0;
      if (steer_ctl[2]) begin
         if (ce_sel) e_ce = pt_in[2];
         else        e_ia = pt_in[2];
      end
      chk(steer_ctl[2] ? "R6" : "R9", mc_ce, e_ce);
      chk(steer_ctl[2] ? "R6" : "R9", mc_init_a, e_ia);
      chk("R7", mc_init_b, steer_ctl[3] ? pt_in[3] : 1'b0);
      chk("R8", mc_oe, steer_ctl[4] ? pt_in[4] : 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Idle state: all terms on logic, all zero (R1)
      chk("R1", or_bypass, 1'b0);
      chk("R1", mc_ce, 1'b1);
      chk("R1", mc_oe, 1'b0);
      for (int m = 0; m < 32; m++) begin
         for (int p = 0; p < 32; p++) begin
            for (int s = 0; s < 4; s++) begin
               @(negedge clk);
               steer_ctl = m[4:0];
               pt_in     = p[4:0];
               ce_sel    = s[0];
               glb_clk   = s[1];
               #5;
               check_all();
            end
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule